// File: doc/BRIEF.md
# Windowed Instruction Trace Buffer

This block records what an 8-bit processor retires into an on-chip store of `DEPTH` words, so that a debugger can later replay the executed path. A retire strobe comes with the program counter, the accumulator and one register value chosen inside the core. Recording is armed by the debugger and starts at the first retired instruction whose address matches a trigger address. From then on, an optional inclusive address range can restrict which instructions are kept.

Two packing modes exist. A full record keeps the address, the accumulator and the chosen register in one word. The address-only mode puts two addresses in each word, which doubles the number of instructions the store can hold. When the store is full, the block applies one of two policies: it keeps recording and overwrites the oldest words, or it stops recording and asks the processor to halt. Once capture is disarmed, the debugger reads the words back by logical index, and index 0 is always the oldest word.

Top module: `itrace_buffer`

## Requirements
- R1: After reset, `fill_count` is 0, and `halt_req`, `wrapped` and `rd_valid` are all 0.
- R2: A rising edge on `arm` empties the store and latches every `cfg_*` input. Retires are then ignored until one arrives with `ret_pc == cfg_trig_pc`. That instruction is the first one eligible for storage.
- R3: With `cfg_pc_only` = 0, every stored retire takes one word laid out as bits [31:16] = PC, [15:8] = ACC and [7:0] = register value. Capacity is `DEPTH` instructions.
- R4: With `cfg_win_en` = 1, a retire is stored only when `cfg_win_lo <= ret_pc <= cfg_win_hi`, both bounds inclusive. Any other retire leaves `fill_count` unchanged.
- R5: With `cfg_pc_only` = 1, two consecutive stored PCs share one word: the earlier one in bits [15:0] and the later one in bits [31:16]. Capacity is 2×`DEPTH` instructions.
- R6: With `cfg_wrap` = 0, `halt_req` goes to 1 in the cycle after the last word completes (`fill_count` == `DEPTH`). Later retires are then ignored. `halt_req` stays at 1 until `arm` falls.
- R7: With `cfg_wrap` = 1, recording continues past full by overwriting the oldest word. `fill_count` stays at `DEPTH` and `wrapped` goes to 1.
- R8: While `arm` = 0, a cycle with `rd_en` = 1 and `rd_idx` < `fill_count` returns, one cycle later, `rd_valid` = 1 and the word at that logical index. Index 0 is the oldest word and the order is chronological. A read with `rd_idx` >= `fill_count` returns `rd_valid` = 0.
- R9: While `arm` = 1, `rd_en` is ignored and `rd_valid` stays 0.
- R10: In address-only mode, when the newest word holds only one PC, reading that word gives `rd_hi_ok` = 0 with bits [31:16] = 0. Every other valid read gives `rd_hi_ok` = 1.
- R11: `fill_count` equals the number of words holding data, a half-filled word included, and never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Capture active while high; a rising edge restarts capture |
| cfg_trig_pc | input | 16 | Address that starts recording |
| cfg_win_en | input | 1 | Enable the address window |
| cfg_win_lo | input | 16 | Window low bound (inclusive) |
| cfg_win_hi | input | 16 | Window high bound (inclusive) |
| cfg_pc_only | input | 1 | Pack two PCs per word |
| cfg_wrap | input | 1 | 1 = overwrite oldest, 0 = halt when full |
| retire | input | 1 | Instruction retire strobe |
| ret_pc | input | 16 | Program counter of the retiring instruction |
| ret_acc | input | 8 | Accumulator value |
| ret_reg | input | 8 | Chosen register value |
| rd_en | input | 1 | Read request |
| rd_idx | input | 10 | Logical word index, 0 = oldest |
| halt_req | output | 1 | Halt request to the processor |
| fill_count | output | 10 | Words holding data |
| wrapped | output | 1 | Oldest data has been overwritten |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read word |
| rd_hi_ok | output | 1 | Upper half of the read word holds a PC |

## Verification
A retire that the clock edge samples shows up in `fill_count`, `wrapped` and `halt_req` right after that same edge. The bench drives each retire for one cycle from a falling edge and checks these outputs at the next falling edge. A read request returns its word on the edge after it is sampled, so the bench checks `rd_valid`, `rd_data` and `rd_hi_ok` one falling edge after it raises `rd_en`. The expected words are rebuilt from the bench's own list of accepted retires and its own count of the capacity.

// File: rtl/itrace_pkg.sv
package itrace_pkg;
   typedef enum logic [1:0] {
      CAP_OFF  = 2'd0,
      CAP_WAIT = 2'd1,
      CAP_RUN  = 2'd2
   } cap_state_e;
endpackage

// File: rtl/itrace_gate.sv
module itrace_gate
   import itrace_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm,
   input  logic            arm_rise,
   input  logic [PC_W-1:0] trig_pc,
   input  logic            win_en,
   input  logic [PC_W-1:0] win_lo,
   input  logic [PC_W-1:0] win_hi,
   input  logic            retire,
   input  logic [PC_W-1:0] pc,
   output logic            accept
);
   cap_state_e state_q, state_d;
   logic       hit_trig;
   logic       in_win;

   assign hit_trig = retire && (pc == trig_pc);
   assign in_win   = !win_en || ((pc >= win_lo) && (pc <= win_hi));

   always_comb begin
      state_d = state_q;
      if (!arm) begin
         state_d = CAP_OFF;
      end else if (arm_rise) begin
         state_d = CAP_WAIT;
      end else if (state_q == CAP_WAIT && hit_trig) begin
         state_d = CAP_RUN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= CAP_OFF;
      else        state_q <= state_d;
   end

   assign accept = arm && !arm_rise && retire && in_win &&
                   ((state_q == CAP_RUN) || (state_q == CAP_WAIT && hit_trig));
endmodule

// File: rtl/itrace_wrctl.sv
module itrace_wrctl #(
   parameter int DEPTH  = 1000,
   parameter int PC_W   = 16,
   parameter int DAT_W  = 8,
   parameter int WORD_W = 32,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              accept,
   input  logic              pc_only,
   input  logic              wrap_en,
   input  logic [PC_W-1:0]   pc,
   input  logic [DAT_W-1:0]  acc,
   input  logic [DAT_W-1:0]  sel,
   output logic              we,
   output logic [IDX_W-1:0]  waddr,
   output logic [WORD_W-1:0] wdata,
   output logic [IDX_W-1:0]  wr_ptr,
   output logic [IDX_W-1:0]  ptr_nxt,
   output logic [CNT_W-1:0]  fill,
   output logic              half_pend,
   output logic              wrapped,
   output logic              stopped
);
   localparam int FULL_PAD = WORD_W - PC_W - 2 * DAT_W;
   localparam int HALF_PAD = WORD_W - 2 * PC_W;

   logic [PC_W-1:0]   held_pc;
   logic [WORD_W-1:0] full_word;
   logic [WORD_W-1:0] lo_word;
   logic [WORD_W-1:0] pair_word;
   logic              is_full;
   logic              take;
   logic              new_word;

   generate
      if (DEPTH == (1 << IDX_W)) begin : g_ptr_pow2
         assign ptr_nxt = wr_ptr + 1'b1;
      end else begin : g_ptr_cmp
         assign ptr_nxt = (wr_ptr == IDX_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end

      if (FULL_PAD == 0) begin : g_full_nopad
         assign full_word = {pc, acc, sel};
      end else begin : g_full_pad
         assign full_word = {{FULL_PAD{1'b0}}, pc, acc, sel};
      end

      if (HALF_PAD == 0) begin : g_half_nopad
         assign lo_word   = {{PC_W{1'b0}}, pc};
         assign pair_word = {pc, held_pc};
      end else begin : g_half_pad
         assign lo_word   = {{(HALF_PAD + PC_W){1'b0}}, pc};
         assign pair_word = {{HALF_PAD{1'b0}}, pc, held_pc};
      end
   endgenerate

   assign is_full  = (fill == CNT_W'(DEPTH)) && !half_pend;
   assign stopped  = is_full && !wrap_en;
   assign take     = accept && !stopped;
   assign new_word = !pc_only || !half_pend;

   assign we    = take;
   assign waddr = wr_ptr;
   assign wdata = !pc_only ? full_word : (half_pend ? pair_word : lo_word);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         fill      <= '0;
         half_pend <= 1'b0;
         wrapped   <= 1'b0;
         held_pc   <= '0;
      end else if (clear) begin
         wr_ptr    <= '0;
         fill      <= '0;
         half_pend <= 1'b0;
         wrapped   <= 1'b0;
         held_pc   <= '0;
      end else if (take) begin
         if (new_word) begin
            if (fill == CNT_W'(DEPTH)) wrapped <= 1'b1;
            else                       fill    <= fill + 1'b1;
         end
         if (pc_only && !half_pend) begin
            half_pend <= 1'b1;
            held_pc   <= pc;
         end else begin
            half_pend <= 1'b0;
            wr_ptr    <= ptr_nxt;
         end
      end
   end
endmodule

// File: rtl/itrace_store.sv
module itrace_store #(
   parameter int DEPTH  = 1000,
   parameter int WORD_W = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              re,
   input  logic [IDX_W-1:0]  raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/itrace_rdport.sv
module itrace_rdport #(
   parameter int DEPTH  = 1000,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [CNT_W-1:0] fill,
   input  logic             wrapped,
   input  logic             half_pend,
   input  logic             pc_only,
   input  logic [IDX_W-1:0] wr_ptr,
   input  logic [IDX_W-1:0] ptr_nxt,
   output logic             re,
   output logic [IDX_W-1:0] raddr,
   output logic             rd_valid,
   output logic             rd_hi_ok
);
   logic [IDX_W-1:0] base;
   logic [IDX_W:0]   sum;
   logic             last_half;

   assign base = !wrapped ? '0 : (half_pend ? ptr_nxt : wr_ptr);
   assign sum  = {1'b0, base} + {1'b0, rd_idx};
   assign raddr = (sum >= (IDX_W + 1)'(DEPTH)) ? IDX_W'(sum - (IDX_W + 1)'(DEPTH))
                                               : sum[IDX_W-1:0];
   assign re        = rd_en && !arm && (CNT_W'(rd_idx) < fill);
   assign last_half = pc_only && half_pend && (CNT_W'(rd_idx) == fill - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_hi_ok <= 1'b0;
      end else begin
         rd_valid <= re;
         rd_hi_ok <= re && !last_half;
      end
   end
endmodule

// File: rtl/itrace_buffer.sv
module itrace_buffer #(
   parameter int DEPTH  = 1000,
   parameter int PC_W   = 16,
   parameter int DAT_W  = 8,
   parameter int WORD_W = 32,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [PC_W-1:0]   cfg_trig_pc,
   input  logic              cfg_win_en,
   input  logic [PC_W-1:0]   cfg_win_lo,
   input  logic [PC_W-1:0]   cfg_win_hi,
   input  logic              cfg_pc_only,
   input  logic              cfg_wrap,
   input  logic              retire,
   input  logic [PC_W-1:0]   ret_pc,
   input  logic [DAT_W-1:0]  ret_acc,
   input  logic [DAT_W-1:0]  ret_reg,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              halt_req,
   output logic [CNT_W-1:0]  fill_count,
   output logic              wrapped,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_hi_ok
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("itrace_buffer: DEPTH must be at least 2");
      end
      if (WORD_W < PC_W + 2 * DAT_W) begin : g_bad_full
         $error("itrace_buffer: WORD_W too narrow for a full record");
      end
      if (WORD_W < 2 * PC_W) begin : g_bad_half
         $error("itrace_buffer: WORD_W too narrow for two PCs");
      end
   endgenerate

   logic              arm_q;
   logic              arm_rise;
   logic              cap_armed;
   logic [PC_W-1:0]   trig_q;
   logic              win_en_q;
   logic [PC_W-1:0]   win_lo_q;
   logic [PC_W-1:0]   win_hi_q;
   logic              pc_only_q;
   logic              wrap_q;
   logic              accept;
   logic              we;
   logic [IDX_W-1:0]  waddr;
   logic [WORD_W-1:0] wdata;
   logic [IDX_W-1:0]  wr_ptr;
   logic [IDX_W-1:0]  ptr_nxt;
   logic              half_pend;
   logic              stopped;
   logic              re;
   logic [IDX_W-1:0]  raddr;

   assign arm_rise  = arm && !arm_q;
   assign cap_armed = arm && arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q     <= 1'b0;
         trig_q    <= '0;
         win_en_q  <= 1'b0;
         win_lo_q  <= '0;
         win_hi_q  <= '0;
         pc_only_q <= 1'b0;
         wrap_q    <= 1'b0;
      end else begin
         arm_q <= arm;
         if (arm_rise) begin
            trig_q    <= cfg_trig_pc;
            win_en_q  <= cfg_win_en;
            win_lo_q  <= cfg_win_lo;
            win_hi_q  <= cfg_win_hi;
            pc_only_q <= cfg_pc_only;
            wrap_q    <= cfg_wrap;
         end
      end
   end

   itrace_gate #(.PC_W(PC_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .arm_rise (arm_rise),
      .trig_pc  (trig_q),
      .win_en   (win_en_q),
      .win_lo   (win_lo_q),
      .win_hi   (win_hi_q),
      .retire   (retire),
      .pc       (ret_pc),
      .accept   (accept)
   );

   itrace_wrctl #(.DEPTH(DEPTH), .PC_W(PC_W), .DAT_W(DAT_W), .WORD_W(WORD_W)) u_wrctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (arm_rise),
      .accept    (accept),
      .pc_only   (pc_only_q),
      .wrap_en   (wrap_q),
      .pc        (ret_pc),
      .acc       (ret_acc),
      .sel       (ret_reg),
      .we        (we),
      .waddr     (waddr),
      .wdata     (wdata),
      .wr_ptr    (wr_ptr),
      .ptr_nxt   (ptr_nxt),
      .fill      (fill_count),
      .half_pend (half_pend),
      .wrapped   (wrapped),
      .stopped   (stopped)
   );

   itrace_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .re    (re),
      .raddr (raddr),
      .rdata (rd_data)
   );

   itrace_rdport #(.DEPTH(DEPTH)) u_rdport (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm),
      .rd_en     (rd_en),
      .rd_idx    (rd_idx),
      .fill      (fill_count),
      .wrapped   (wrapped),
      .half_pend (half_pend),
      .pc_only   (pc_only_q),
      .wr_ptr    (wr_ptr),
      .ptr_nxt   (ptr_nxt),
      .re        (re),
      .raddr     (raddr),
      .rd_valid  (rd_valid),
      .rd_hi_ok  (rd_hi_ok)
   );

   assign halt_req = cap_armed && stopped;
endmodule

// File: rtl/itrace_buffer_chk.sv
module itrace_buffer_chk #(
   parameter int DEPTH = 1000,
   parameter int PC_W  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm,
   input logic             retire,
   input logic [PC_W-1:0]  ret_pc,
   input logic             rd_en,
   input logic             halt_req,
   input logic [CNT_W-1:0] fill_count,
   input logic             wrapped,
   input logic             rd_valid,
   input logic             cap_armed,
   input logic             win_en_q,
   input logic [PC_W-1:0]  win_lo_q,
   input logic [PC_W-1:0]  win_hi_q
);
   // R11
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= CNT_W'(DEPTH));

   // R9
   rd_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && rd_en) |=> !rd_valid);

   // R6
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req && arm) |=> ($stable(fill_count) && halt_req == arm));

   // R7
   wrap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrapped |-> (fill_count == CNT_W'(DEPTH)));

   // R4
   win_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_armed && win_en_q && retire && ((ret_pc < win_lo_q) || (ret_pc > win_hi_q)))
      |=> $stable(fill_count));

   // R6
   idle_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |-> !halt_req);
endmodule

bind itrace_buffer itrace_buffer_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arm        (arm),
   .retire     (retire),
   .ret_pc     (ret_pc),
   .rd_en      (rd_en),
   .halt_req   (halt_req),
   .fill_count (fill_count),
   .wrapped    (wrapped),
   .rd_valid   (rd_valid),
   .cap_armed  (cap_armed),
   .win_en_q   (win_en_q),
   .win_lo_q   (win_lo_q),
   .win_hi_q   (win_hi_q)
);

// File: tb/itrace_buffer_tb.sv
module itrace_buffer_tb;
   localparam int DEPTH = 1000;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int MAXR  = 4096;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              arm = 1'b0;
   logic [15:0]       cfg_trig_pc = '0;
   logic              cfg_win_en = 1'b0;
   logic [15:0]       cfg_win_lo = '0;
   logic [15:0]       cfg_win_hi = '0;
   logic              cfg_pc_only = 1'b0;
   logic              cfg_wrap = 1'b0;
   logic              retire = 1'b0;
   logic [15:0]       ret_pc = '0;
   logic [7:0]        ret_acc = '0;
   logic [7:0]        ret_reg = '0;
   logic              rd_en = 1'b0;
   logic [IDX_W-1:0]  rd_idx = '0;
   logic              halt_req;
   logic [CNT_W-1:0]  fill_count;
   logic              wrapped;
   logic              rd_valid;
   logic [31:0]       rd_data;
   logic              rd_hi_ok;

   always #10 clk = ~clk;

   itrace_buffer u_dut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_trig_pc(cfg_trig_pc),
      .cfg_win_en(cfg_win_en), .cfg_win_lo(cfg_win_lo), .cfg_win_hi(cfg_win_hi),
      .cfg_pc_only(cfg_pc_only), .cfg_wrap(cfg_wrap), .retire(retire),
      .ret_pc(ret_pc), .ret_acc(ret_acc), .ret_reg(ret_reg), .rd_en(rd_en),
      .rd_idx(rd_idx), .halt_req(halt_req), .fill_count(fill_count),
      .wrapped(wrapped), .rd_valid(rd_valid), .rd_data(rd_data), .rd_hi_ok(rd_hi_ok)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model of accepted retires
   logic [15:0] m_pc  [MAXR];
   logic [7:0]  m_acc [MAXR];
   logic [7:0]  m_reg [MAXR];
   int          m_n = 0;
   bit          m_run = 0;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int words_total();
      return cfg_pc_only ? (m_n + 1) / 2 : m_n;
   endfunction

   function automatic int exp_fill();
      return (words_total() > DEPTH) ? DEPTH : words_total();
   endfunction

   function automatic logic exp_hi_ok(int l);
      int a;
      a = words_total() - exp_fill() + l;
      if (!cfg_pc_only) return 1'b1;
      return (2 * a + 1) < m_n;
   endfunction

   function automatic logic [31:0] exp_word(int l);
      int a;
      a = words_total() - exp_fill() + l;
      if (!cfg_pc_only) return {m_pc[a], m_acc[a], m_reg[a]};
      if ((2 * a + 1) < m_n) return {m_pc[2 * a + 1], m_pc[2 * a]};
      return {16'h0000, m_pc[2 * a]};
   endfunction

   task automatic start(logic [15:0] trig, logic wen, logic [15:0] lo, logic [15:0] hi,
                        logic pco, logic wrp);
      cfg_trig_pc = trig; cfg_win_en = wen; cfg_win_lo = lo; cfg_win_hi = hi;
      cfg_pc_only = pco; cfg_wrap = wrp;
      arm = 1'b1;
      m_n = 0; m_run = 0;
      @(negedge clk);
      check("R2 cleared on arm", 32'(fill_count), 32'd0);
   endtask

   task automatic stop();
      arm = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_retire(logic [15:0] pc, logic [7:0] a, logic [7:0] r);
      bit inwin;
      bit full;
      retire = 1'b1; ret_pc = pc; ret_acc = a; ret_reg = r;
      if (!m_run && pc == cfg_trig_pc) m_run = 1;
      inwin = !cfg_win_en || (pc >= cfg_win_lo && pc <= cfg_win_hi);
      full = cfg_pc_only ? (m_n >= 2 * DEPTH) : (m_n >= DEPTH);
      if (m_run && inwin && !(full && !cfg_wrap) && m_n < MAXR) begin
         m_pc[m_n] = pc; m_acc[m_n] = a; m_reg[m_n] = r; m_n++;
      end
      @(negedge clk);
      retire = 1'b0;
   endtask

   task automatic rand_retires(int n, logic [15:0] base, int span);
      for (int i = 0; i < n; i++) begin
         logic [15:0] pc;
         pc = base + 16'($urandom_range(span - 1, 0));
         if (!m_run && pc == cfg_trig_pc) pc = pc ^ 16'h0001;
         do_retire(pc, 8'($urandom), 8'($urandom));
      end
   endtask

   task automatic read_word(int l);
      rd_en = 1'b1; rd_idx = IDX_W'(l);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic verify_all(string req);
      check({req, " R11 fill"}, 32'(fill_count), 32'(exp_fill()));
      check({req, " R7 wrapped"}, 32'(wrapped), 32'(words_total() > DEPTH));
      for (int l = 0; l < exp_fill(); l++) begin
         read_word(l);
         check({req, " R8 valid"}, 32'(rd_valid), 32'd1);
         check({req, " R8 data"}, rd_data, exp_word(l));
         check({req, " R10 hi_ok"}, 32'(rd_hi_ok), 32'(exp_hi_ok(l)));
      end
      if (exp_fill() < DEPTH) begin
         read_word(exp_fill());
         check({req, " R8 out of range"}, 32'(rd_valid), 32'd0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 fill", 32'(fill_count), 32'd0);
      check("R1 halt", 32'(halt_req), 32'd0);
      check("R1 wrapped", 32'(wrapped), 32'd0);
      check("R1 rd_valid", 32'(rd_valid), 32'd0);

      // R2/R3: full records, trigger start, no window
      start(16'h0100, 1'b0, '0, '0, 1'b0, 1'b0);
      rand_retires(40, 16'h0200, 256);
      check("R2 nothing before trigger", 32'(fill_count), 32'd0);
      do_retire(16'h0100, 8'hA5, 8'h5A);
      check("R2 trigger stored", 32'(fill_count), 32'd1);
      rand_retires(300, 16'h0000, 4096);
      read_word(0);
      check("R9 read ignored while armed", 32'(rd_valid), 32'd0);
      stop();
      verify_all("R3 full");

      // R4: inclusive window, trigger outside window
      start(16'h0800, 1'b1, 16'h1000, 16'h1040, 1'b0, 1'b0);
      do_retire(16'h0800, 8'h01, 8'h02);
      check("R4 trigger outside window not stored", 32'(fill_count), 32'd0);
      do_retire(16'h0FFF, 8'h11, 8'h12);
      check("R4 below low bound", 32'(fill_count), 32'd0);
      do_retire(16'h1000, 8'h21, 8'h22);
      check("R4 at low bound", 32'(fill_count), 32'd1);
      do_retire(16'h1040, 8'h31, 8'h32);
      check("R4 at high bound", 32'(fill_count), 32'd2);
      do_retire(16'h1041, 8'h41, 8'h42);
      check("R4 above high bound", 32'(fill_count), 32'd2);
      rand_retires(120, 16'h0FF0, 96);
      stop();
      verify_all("R4 window");

      // R5/R10: PC-only, odd count, no wrap
      start(16'h0300, 1'b0, '0, '0, 1'b1, 1'b0);
      do_retire(16'h0300, 8'h00, 8'h00);
      rand_retires(200, 16'h0000, 65535);
      stop();
      check("R10 odd count setup", 32'(m_n % 2), 32'd1);
      verify_all("R5 pc-only odd");

      // R6/R5: PC-only break at 2*DEPTH
      start(16'h0400, 1'b0, '0, '0, 1'b1, 1'b0);
      do_retire(16'h0400, 8'h00, 8'h00);
      rand_retires(2 * DEPTH - 2, 16'h0000, 65535);
      check("R6 no halt before full", 32'(halt_req), 32'd0);
      rand_retires(1, 16'h0000, 65535);
      check("R5 capacity 2*DEPTH", 32'(fill_count), 32'(DEPTH));
      check("R6 halt when full", 32'(halt_req), 32'd1);
      rand_retires(5, 16'h0000, 65535);
      check("R6 halt held", 32'(halt_req), 32'd1);
      stop();
      check("R6 halt drops with arm", 32'(halt_req), 32'd0);
      verify_all("R6 pc-only break");

      // R3/R6: full-record break at DEPTH
      start(16'h0500, 1'b0, '0, '0, 1'b0, 1'b0);
      do_retire(16'h0500, 8'h77, 8'h88);
      rand_retires(DEPTH - 1, 16'h0000, 65535);
      check("R6 full-record halt", 32'(halt_req), 32'd1);
      rand_retires(3, 16'h0000, 65535);
      stop();
      verify_all("R6 full break");

      // R7: full-record wrap
      start(16'h0600, 1'b0, '0, '0, 1'b0, 1'b1);
      do_retire(16'h0600, 8'h10, 8'h20);
      rand_retires(DEPTH + 299, 16'h0000, 65535);
      check("R7 no halt in wrap", 32'(halt_req), 32'd0);
      stop();
      verify_all("R7 full wrap");

      // R7/R10: PC-only wrap ending on a half word
      start(16'h0700, 1'b0, '0, '0, 1'b1, 1'b1);
      do_retire(16'h0700, 8'h00, 8'h00);
      rand_retires(2 * DEPTH + 100, 16'h0000, 65535);
      stop();
      check("R10 odd wrap setup", 32'(m_n % 2), 32'd1);
      verify_all("R7 pc-only wrap");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule